// File: doc/BRIEF.md
# Write Leveling and Read Slip Sequencer

This block runs the write-leveling calibration of a DDR3 interface with no processor involved. On a start pulse it puts the DRAM into leveling mode with a mode-register write, then raises the PHY leveling enable. It then visits every byte lane in turn. For each lane it clears the lane's output delays and probes the lane: it fires a leveling strobe, waits a settle time and reads back the lane's feedback byte. It keeps stepping the DQ and DQS output delays together until it finds the edge where the feedback turns from zero to nonzero. The number of steps it took is that lane's delay.

A lane whose feedback is already nonzero at zero delay is taken to carry more than one bit time of skew. Such a lane is first driven down into the zero zone and then searched for the rising edge. When every lane is done, the block leaves leveling mode with a second mode-register write and drops the enable. If leveling succeeded, it then picks out the lanes whose delay lies above half the smallest high-skew delay and issues read-bitslip pulses to each of them. A single done pulse closes the run, and the pass level is valid while done is high.

Mode-register writes leave the block on a valid/ready command port. While valid is high and ready is low, the payload is held unchanged. The sequencer waits, with no time limit, for ready, and moves on only in the cycle after the handshake. All other pins are plain single-cycle pulses or levels.

Top module: `wlvl_seq`

## Requirements
- R1: After reset, and whenever no run is active, cmd_valid, lvl_en, lane_sel, busy, done, wdly_rst, wdly_inc, lvl_strobe and rd_slip are all 0.
- R2: A start pulse while idle produces exactly one entry command. Its fields are cmd_addr = MR1_BASE with bit LVL_BIT set, cmd_bank = MR_BANK, and cmd_ras, cmd_cas, cmd_we and cmd_cs all 1. The payload stays stable while cmd_valid is high and cmd_ready is low. lvl_en rises in the cycle after the handshake.
- R3: Lanes are visited in ascending index order. Each lane receives exactly one wdly_rst pulse, which comes before its first strobe. lane_sel is one-hot on the visited lane during all of that lane's pulses.
- R4: A probe is one lvl_strobe pulse followed by a sample of fb_byte SETTLE cycles later. A sample counts as high when any bit is set. Strobes occur only while lvl_en is high. wdly_inc never comes sooner than SETTLE cycles after a strobe, and no two of strobe, wdly_inc, wdly_rst and rd_slip are ever high together.
- R5: A lane whose first sample is high is marked high-skew. Its delay is stepped, with a probe after every step, until a sample reads zero, and then further until a sample reads high. The delay is the number of steps, and the lane sees delay+1 strobes.
- R6: A lane whose first sample is zero is not high-skew. It is stepped until a sample reads high, and its delay is the number of steps.
- R7: A lane that would need a count of MAX_DLY stops at MAX_DLY after MAX_DLY-1 wdly_inc pulses. Any such lane makes pass 0.
- R8: After the last lane, exactly one exit command is sent. It is equal to the entry command except that bit LVL_BIT of cmd_addr is cleared. lvl_en falls in the cycle after that handshake.
- R9: On a passing run with at least one high-skew lane, the threshold is half (rounded down) of the smallest high-skew delay. Every lane whose delay exceeds the threshold receives SLIP_PULSES separate rd_slip pulses, with lane_sel one-hot on that lane. Lanes are served from the highest index down.
- R10: No rd_slip pulse occurs when no lane is high-skew or when the run fails.
- R11: done is high for exactly one cycle at the end of a run, and busy falls in the cycle after. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (ignored while busy) |
| cmd_valid | output | 1 | Mode-register command is valid |
| cmd_ready | input | 1 | Command accepted by the sink |
| cmd_addr | output | ADDR_W | Mode-register address/value field |
| cmd_bank | output | BANK_W | Bank address of the command |
| cmd_ras | output | 1 | Row strobe bit of the command (1 = asserted) |
| cmd_cas | output | 1 | Column strobe bit of the command (1 = asserted) |
| cmd_we | output | 1 | Write-enable bit of the command (1 = asserted) |
| cmd_cs | output | 1 | Chip-select bit of the command (1 = asserted) |
| lvl_en | output | 1 | PHY leveling enable |
| lane_sel | output | LANES | One-hot lane select for delay and slip pulses |
| wdly_rst | output | 1 | Reset DQ and DQS write delays of the selected lane |
| wdly_inc | output | 1 | Step DQ and DQS write delays of the selected lane |
| lvl_strobe | output | 1 | Leveling strobe pulse |
| fb_byte | input | FB_W | Leveling feedback byte of the selected lane |
| rd_slip | output | 1 | Read bitslip pulse for the selected lane |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run result, valid while done is high |

## Verification
The stored delay and skew flag of a lane can be wrong, or the search phase can be lost. Either fault first shows up at the ports as a wrong number of wdly_inc pulses or strobes for that lane, within the same lane visit. The bitslip choice made from the stored values only shows up after the exit command. There it appears as a missing or extra group of rd_slip pulses, or as a wrong lane order. A lost handshake or a wrong mode-register field shows up at the command port at once, and a run that stalls on one shows up as a missing done pulse.

// File: rtl/wlvl_pkg.sv
`timescale 1ns/1ps
package wlvl_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ON_CMD,
    S_ON_WAIT,
    S_LANE_RST,
    S_PROBE_GO,
    S_PROBE_WAIT,
    S_STEP_INC,
    S_LANE_END,
    S_OFF_CMD,
    S_SLIP_PICK,
    S_SLIP_PULSE,
    S_SLIP_GAP,
    S_SLIP_NEXT,
    S_DONE
  } seq_state_t;

endpackage

// File: rtl/wlvl_cmd_port.sv
`timescale 1ns/1ps
module wlvl_cmd_port #(
  parameter int ADDR_W            = 16,
  parameter int BANK_W            = 3,
  parameter logic [15:0] MR1_BASE = 16'h0044,
  parameter int LVL_BIT           = 7,
  parameter int MR_BANK           = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_on,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              cmd_ras,
  output logic              cmd_cas,
  output logic              cmd_we,
  output logic              cmd_cs,
  output logic              accept
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(MR1_BASE);
  localparam logic [ADDR_W-1:0] LVL_M  = ADDR_W'(1) << LVL_BIT;

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;

  assign accept = valid_q && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b0;
    end else if (req && !valid_q) begin
      valid_q <= 1'b1;
      addr_q  <= req_on ? (BASE_A | LVL_M) : (BASE_A & ~LVL_M);
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_addr  = addr_q;
  assign cmd_bank  = BANK_W'(MR_BANK);
  assign cmd_ras   = valid_q;
  assign cmd_cas   = valid_q;
  assign cmd_we    = valid_q;
  assign cmd_cs    = valid_q;

endmodule

// File: rtl/wlvl_probe.sv
`timescale 1ns/1ps
module wlvl_probe #(
  parameter int SETTLE = 10,
  parameter int FB_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [FB_W-1:0] fb,
  output logic            strobe,
  output logic            res_v,
  output logic            res_nz
);

  localparam int SET_W = $clog2(SETTLE + 1);

  logic [SET_W-1:0] wait_q;
  logic             active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q   <= '0;
      active_q <= 1'b0;
      strobe   <= 1'b0;
      res_v    <= 1'b0;
      res_nz   <= 1'b0;
    end else begin
      strobe <= 1'b0;
      res_v  <= 1'b0;
      if (go && !active_q) begin
        strobe   <= 1'b1;
        active_q <= 1'b1;
        wait_q   <= SET_W'(SETTLE);
      end else if (active_q) begin
        if (wait_q <= SET_W'(1)) begin
          active_q <= 1'b0;
          res_v    <= 1'b1;
          res_nz   <= |fb;
        end else begin
          wait_q <= wait_q - SET_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/wlvl_lane_book.sv
`timescale 1ns/1ps
module wlvl_lane_book #(
  parameter int LANES   = 4,
  parameter int MAX_DLY = 32,
  parameter int DLY_W   = $clog2(MAX_DLY + 1),
  parameter int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [DLY_W-1:0]  wr_dly,
  input  logic              wr_skew,
  output logic [LANES-1:0]  slip_mask,
  output logic              all_ok
);

  logic [DLY_W-1:0] dly_q [LANES];
  logic [LANES-1:0] skew_q;
  logic [DLY_W-1:0] min_d;
  logic             any_skew;
  logic [DLY_W-1:0] thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) dly_q[i] <= '0;
      skew_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_lane == LANE_W'(i)) begin
          dly_q[i]  <= wr_dly;
          skew_q[i] <= wr_skew;
        end
      end
    end
  end

  always_comb begin
    min_d    = '0;
    any_skew = 1'b0;
    all_ok   = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (skew_q[i] && (!any_skew || dly_q[i] < min_d)) begin
        min_d    = dly_q[i];
        any_skew = 1'b1;
      end
      if (dly_q[i] >= DLY_W'(MAX_DLY)) all_ok = 1'b0;
    end
  end

  assign thr = min_d >> 1;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign slip_mask[g] = any_skew && (dly_q[g] > thr);
  end

endmodule

// File: rtl/wlvl_seq.sv
`timescale 1ns/1ps
module wlvl_seq
  import wlvl_pkg::*;
#(
  parameter int LANES             = 4,
  parameter int MAX_DLY           = 32,
  parameter int SETTLE            = 10,
  parameter int ENTRY_WAIT        = 100,
  parameter int SLIP_PULSES       = 3,
  parameter int FB_W              = 8,
  parameter int ADDR_W            = 16,
  parameter int BANK_W            = 3,
  parameter logic [15:0] MR1_BASE = 16'h0044,
  parameter int LVL_BIT           = 7,
  parameter int MR_BANK           = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              cmd_ras,
  output logic              cmd_cas,
  output logic              cmd_we,
  output logic              cmd_cs,
  output logic              lvl_en,
  output logic [LANES-1:0]  lane_sel,
  output logic              wdly_rst,
  output logic              wdly_inc,
  output logic              lvl_strobe,
  input  logic [FB_W-1:0]   fb_byte,
  output logic              rd_slip,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int DLY_W  = $clog2(MAX_DLY + 1);
  localparam int EW_W   = $clog2(ENTRY_WAIT + 1);
  localparam int SL_W   = $clog2(SLIP_PULSES + 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  seq_state_t        state_q;
  logic [LANE_W-1:0] lane_q;
  logic [LANE_W-1:0] slip_lane_q;
  logic [DLY_W-1:0]  cnt_q;
  logic              phase_low_q;
  logic              first_q;
  logic              skew_q;
  logic [EW_W-1:0]   wait_q;
  logic [SL_W-1:0]   slip_n_q;
  logic              lvl_en_q;
  logic              pass_q;

  logic              cmd_req, cmd_on, accept;
  logic              probe_go, res_v, res_nz;
  logic [LANES-1:0]  slip_mask;
  logic              all_ok;
  logic              step;

  assign cmd_req  = (state_q == S_IDLE && start) ||
                    (state_q == S_LANE_END && lane_q == LAST_LANE);
  assign cmd_on   = (state_q == S_IDLE);
  assign probe_go = (state_q == S_PROBE_GO);

  wlvl_cmd_port #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MR1_BASE(MR1_BASE),
    .LVL_BIT(LVL_BIT), .MR_BANK(MR_BANK)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n), .req(cmd_req), .req_on(cmd_on),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_bank(cmd_bank), .cmd_ras(cmd_ras), .cmd_cas(cmd_cas),
    .cmd_we(cmd_we), .cmd_cs(cmd_cs), .accept(accept)
  );

  wlvl_probe #(.SETTLE(SETTLE), .FB_W(FB_W)) u_probe (
    .clk(clk), .rst_n(rst_n), .go(probe_go), .fb(fb_byte),
    .strobe(lvl_strobe), .res_v(res_v), .res_nz(res_nz)
  );

  wlvl_lane_book #(.LANES(LANES), .MAX_DLY(MAX_DLY)) u_book (
    .clk(clk), .rst_n(rst_n), .wr_en(state_q == S_LANE_END),
    .wr_lane(lane_q), .wr_dly(cnt_q), .wr_skew(skew_q),
    .slip_mask(slip_mask), .all_ok(all_ok)
  );

  // A zero sample always calls for another step; a high sample does so
  // only while the lane is still being pushed into the zero zone.
  assign step = !res_nz || phase_low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      lane_q      <= '0;
      slip_lane_q <= '0;
      cnt_q       <= '0;
      phase_low_q <= 1'b0;
      first_q     <= 1'b0;
      skew_q      <= 1'b0;
      wait_q      <= '0;
      slip_n_q    <= '0;
      lvl_en_q    <= 1'b0;
      pass_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          pass_q  <= 1'b0;
          state_q <= S_ON_CMD;
        end
        S_ON_CMD: if (accept) begin
          lvl_en_q <= 1'b1;
          wait_q   <= EW_W'(ENTRY_WAIT);
          state_q  <= S_ON_WAIT;
        end
        S_ON_WAIT: begin
          if (wait_q == '0) begin
            lane_q  <= '0;
            state_q <= S_LANE_RST;
          end else begin
            wait_q <= wait_q - EW_W'(1);
          end
        end
        S_LANE_RST: begin
          cnt_q       <= '0;
          phase_low_q <= 1'b1;
          first_q     <= 1'b1;
          skew_q      <= 1'b0;
          state_q     <= S_PROBE_GO;
        end
        S_PROBE_GO: state_q <= S_PROBE_WAIT;
        S_PROBE_WAIT: if (res_v) begin
          first_q <= 1'b0;
          if (first_q) skew_q <= res_nz;
          if (!res_nz) phase_low_q <= 1'b0;
          if (step) begin
            cnt_q <= cnt_q + DLY_W'(1);
            if (cnt_q == DLY_W'(MAX_DLY - 1)) state_q <= S_LANE_END;
            else                              state_q <= S_STEP_INC;
          end else begin
            state_q <= S_LANE_END;
          end
        end
        S_STEP_INC: state_q <= S_PROBE_GO;
        S_LANE_END: begin
          if (lane_q == LAST_LANE) begin
            state_q <= S_OFF_CMD;
          end else begin
            lane_q  <= lane_q + LANE_W'(1);
            state_q <= S_LANE_RST;
          end
        end
        S_OFF_CMD: if (accept) begin
          lvl_en_q    <= 1'b0;
          pass_q      <= all_ok;
          slip_lane_q <= LAST_LANE;
          state_q     <= all_ok ? S_SLIP_PICK : S_DONE;
        end
        S_SLIP_PICK: begin
          if (slip_mask[slip_lane_q]) begin
            slip_n_q <= '0;
            state_q  <= S_SLIP_PULSE;
          end else begin
            state_q <= S_SLIP_NEXT;
          end
        end
        S_SLIP_PULSE: begin
          if (slip_n_q == SL_W'(SLIP_PULSES - 1)) begin
            state_q <= S_SLIP_NEXT;
          end else begin
            slip_n_q <= slip_n_q + SL_W'(1);
            state_q  <= S_SLIP_GAP;
          end
        end
        S_SLIP_GAP: state_q <= S_SLIP_PULSE;
        S_SLIP_NEXT: begin
          if (slip_lane_q == '0) begin
            state_q <= S_DONE;
          end else begin
            slip_lane_q <= slip_lane_q - LANE_W'(1);
            state_q     <= S_SLIP_PICK;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      S_LANE_RST, S_PROBE_GO, S_PROBE_WAIT, S_STEP_INC, S_LANE_END:
        lane_sel = LANES'(1) << lane_q;
      S_SLIP_PULSE, S_SLIP_GAP:
        lane_sel = LANES'(1) << slip_lane_q;
      default:
        lane_sel = '0;
    endcase
  end

  assign lvl_en   = lvl_en_q;
  assign wdly_rst = (state_q == S_LANE_RST);
  assign wdly_inc = (state_q == S_STEP_INC);
  assign rd_slip  = (state_q == S_SLIP_PULSE);
  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_DONE);
  assign pass     = pass_q;

endmodule

// File: rtl/wlvl_seq_chk.sv
`timescale 1ns/1ps
module wlvl_seq_chk #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              lvl_en,
  input logic [LANES-1:0]  lane_sel,
  input logic              wdly_rst,
  input logic              wdly_inc,
  input logic              lvl_strobe,
  input logic              rd_slip,
  input logic              busy,
  input logic              done
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_valid && !lvl_en && lane_sel == '0 && !wdly_rst && !wdly_inc && !rd_slip));

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_bank)));

  // R2
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_en) |-> $past(cmd_valid && cmd_ready));

  // R8
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_en) |-> $past(cmd_valid && cmd_ready));

  // R3
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_sel));

  // R3
  rst_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdly_rst || wdly_inc) |-> ($countones(lane_sel) == 1 && lvl_en));

  // R4
  strobe_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_strobe |-> lvl_en);

  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lvl_strobe, wdly_inc, wdly_rst, rd_slip}));

  // R9
  slip_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slip |-> (!lvl_en && $countones(lane_sel) == 1));

  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

endmodule

bind wlvl_seq wlvl_seq_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .lvl_en(lvl_en), .lane_sel(lane_sel),
  .wdly_rst(wdly_rst), .wdly_inc(wdly_inc), .lvl_strobe(lvl_strobe),
  .rd_slip(rd_slip), .busy(busy), .done(done)
);

// File: tb/wlvl_seq_tb.sv
`timescale 1ns/1ps
module wlvl_seq_tb;

  localparam int LANES  = 4;
  localparam int MAXD   = 32;
  localparam int SETTLE = 10;
  localparam int SLIPS  = 3;
  localparam logic [15:0] BASE = 16'h0044;
  localparam logic [15:0] ON_A  = BASE | 16'h0080;
  localparam logic [15:0] OFF_A = BASE & ~16'h0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_ready = 1'b0;
  logic        cmd_valid, cmd_ras, cmd_cas, cmd_we, cmd_cs;
  logic [15:0] cmd_addr;
  logic [2:0]  cmd_bank;
  logic        lvl_en, wdly_rst, wdly_inc, lvl_strobe, rd_slip, busy, done, pass;
  logic [LANES-1:0] lane_sel;
  logic [7:0]  fb_byte;

  always #4 clk = ~clk;

  wlvl_seq #(.LANES(LANES), .MAX_DLY(MAXD), .SETTLE(SETTLE), .SLIP_PULSES(SLIPS),
             .MR1_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
    .cmd_ras(cmd_ras), .cmd_cas(cmd_cas), .cmd_we(cmd_we), .cmd_cs(cmd_cs),
    .lvl_en(lvl_en), .lane_sel(lane_sel), .wdly_rst(wdly_rst),
    .wdly_inc(wdly_inc), .lvl_strobe(lvl_strobe), .fb_byte(fb_byte),
    .rd_slip(rd_slip), .busy(busy), .done(done), .pass(pass)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Feedback model: high below a, zero in [a,b), high from b up.
  int cfg_a [LANES];
  int cfg_b [LANES];
  int m_dly [LANES];

  int inc_cnt [LANES];
  int rst_cnt [LANES];
  int stb_cnt [LANES];
  int slp_cnt [LANES];
  int last_rst, prev_slip, order_bad, slip_order_bad, gap_bad, stb_bad, since_stb;
  int n_cmd;
  logic [15:0] cmd_log_a [2];
  int cmd_bad;
  bit done_seen, pass_seen;

  always_comb begin
    fb_byte = 8'h00;
    for (int i = 0; i < LANES; i++) begin
      if (lane_sel[i] && (m_dly[i] < cfg_a[i] || m_dly[i] >= cfg_b[i]))
        fb_byte = 8'(1 << ((i + m_dly[i]) % 8));
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      since_stb++;
      for (int i = 0; i < LANES; i++) begin
        if (lane_sel[i]) begin
          if (wdly_rst) begin
            m_dly[i] = 0;
            rst_cnt[i]++;
            if (i <= last_rst) order_bad++;
            last_rst = i;
          end
          if (wdly_inc) begin
            m_dly[i]++;
            inc_cnt[i]++;
            if (since_stb < SETTLE) gap_bad++;
          end
          if (lvl_strobe) stb_cnt[i]++;
          if (rd_slip) begin
            slp_cnt[i]++;
            if (i > prev_slip) slip_order_bad++;
            prev_slip = i;
          end
        end
      end
      if (lvl_strobe) begin
        since_stb = 0;
        if (!lvl_en || lane_sel == '0) stb_bad++;
      end
      if (cmd_valid && cmd_ready) begin
        if (n_cmd < 2) cmd_log_a[n_cmd] = cmd_addr;
        n_cmd++;
        if (cmd_bank != 3'd1 || !cmd_ras || !cmd_cas || !cmd_we || !cmd_cs) cmd_bad++;
      end
      if (done) begin
        done_seen = 1'b1;
        pass_seen = pass;
      end
    end
  end

  int lcg = 7;
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lcg = lcg * 1103515245 + 12345;
      cmd_ready = ((lcg >>> 16) & 3) == 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_dly(input int a, input int b);
    if (a < b) return (b >= MAXD) ? MAXD : b;
    return MAXD;
  endfunction

  function automatic bit exp_skew(input int a, input int b);
    return (a > 0) || (b == 0);
  endfunction

  task automatic run_case(input int a0, input int b0, input int a1, input int b1,
                          input int a2, input int b2, input int a3, input int b3,
                          input bit poke);
    int ed [LANES];
    bit es [LANES];
    int thr, mn, n;
    bit any, ok_all;
    cfg_a[0] = a0; cfg_b[0] = b0; cfg_a[1] = a1; cfg_b[1] = b1;
    cfg_a[2] = a2; cfg_b[2] = b2; cfg_a[3] = a3; cfg_b[3] = b3;
    for (int i = 0; i < LANES; i++) begin
      inc_cnt[i] = 0; rst_cnt[i] = 0; stb_cnt[i] = 0; slp_cnt[i] = 0; m_dly[i] = 0;
    end
    last_rst = -1; prev_slip = LANES; order_bad = 0; slip_order_bad = 0;
    gap_bad = 0; stb_bad = 0; since_stb = 0; n_cmd = 0; cmd_bad = 0;
    done_seen = 1'b0; pass_seen = 1'b0;
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    if (poke) begin
      repeat (300) @(posedge clk);
      #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    n = 0;
    while (!done_seen && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done_seen) begin
      chk(1'b0, "R11 watchdog: run never finished", 0, 1);
      return;
    end
    @(negedge clk);
    chk(!done && !busy, "R11 done one cycle then idle", int'(done) + 2 * int'(busy), 0);

    any = 1'b0; ok_all = 1'b1; mn = 0;
    for (int i = 0; i < LANES; i++) begin
      ed[i] = exp_dly(cfg_a[i], cfg_b[i]);
      es[i] = exp_skew(cfg_a[i], cfg_b[i]);
      if (ed[i] >= MAXD) ok_all = 1'b0;
      if (es[i] && (!any || ed[i] < mn)) begin mn = ed[i]; any = 1'b1; end
    end
    thr = mn / 2;

    chk(n_cmd == 2, "R2 R8 R11 command count", n_cmd, 2);
    chk(cmd_log_a[0] == ON_A, "R2 entry address", int'(cmd_log_a[0]), int'(ON_A));
    chk(cmd_log_a[1] == OFF_A, "R8 exit address", int'(cmd_log_a[1]), int'(OFF_A));
    chk(cmd_bad == 0, "R2 command bank and strobe bits", cmd_bad, 0);
    chk(!lvl_en, "R8 enable low after run", int'(lvl_en), 0);
    chk(pass_seen == ok_all, "R7 pass result", int'(pass_seen), int'(ok_all));
    chk(order_bad == 0, "R3 ascending lane order", order_bad, 0);
    chk(stb_bad == 0 && gap_bad == 0, "R4 strobe gating and settle gap", stb_bad + gap_bad, 0);
    chk(slip_order_bad == 0, "R9 descending slip order", slip_order_bad, 0);
    for (int i = 0; i < LANES; i++) begin
      int ei, esl;
      ei = (ed[i] >= MAXD) ? MAXD - 1 : ed[i];
      chk(rst_cnt[i] == 1, "R3 one delay reset per lane", rst_cnt[i], 1);
      if (ed[i] >= MAXD)
        chk(inc_cnt[i] == ei, "R7 capped step count", inc_cnt[i], ei);
      else if (es[i])
        chk(inc_cnt[i] == ei, "R5 high-skew step count", inc_cnt[i], ei);
      else
        chk(inc_cnt[i] == ei, "R6 normal step count", inc_cnt[i], ei);
      chk(stb_cnt[i] == ei + 1, "R4 R5 R6 probes per lane", stb_cnt[i], ei + 1);
      esl = (ok_all && any && ed[i] > thr) ? SLIPS : 0;
      if (esl == 0)
        chk(slp_cnt[i] == 0, "R10 no slip on lane", slp_cnt[i], 0);
      else
        chk(slp_cnt[i] == esl, "R9 slip pulses on lane", slp_cnt[i], esl);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !lvl_en && lane_sel == '0 && !busy && !done && !rd_slip
        && !wdly_rst && !wdly_inc && !lvl_strobe, "R1 reset state",
        int'(cmd_valid) + int'(busy) + int'(lvl_en), 0);

    // Sweep of lane edge positions, mixing normal and high-skew lanes.
    for (int k = 0; k < 34; k++) begin
      int a1, a2, a3;
      a1 = 1 + k % 5;
      a2 = (k % 3 == 0) ? 0 : (k % 4) + 1;
      a3 = (k % 2 == 1) ? 2 + k % 9 : 0;
      run_case(0, 1 + (k % 31),
               a1, a1 + 2 + (k % 7),
               a2, a2 + 1 + (k * 3) % 20,
               a3, a3 + 3 + (k * 5) % 17, 1'b0);
    end
    // R10: no high-skew lane at all
    run_case(0, 3, 0, 9, 0, 17, 0, 31, 1'b0);
    // R7: edges beyond reach
    run_case(0, 5, 3, 40, 0, 12, 2, 8, 1'b0);
    // R7: feedback never zero, and empty zero zone
    run_case(0, 0, 0, 6, 5, 5, 0, 2, 1'b0);
    // R7: normal lane whose edge sits exactly at the limit
    run_case(0, 32, 1, 4, 0, 2, 0, 3, 1'b0);
    // R9: edge at one step below the limit, all lanes high-skew
    run_case(1, 31, 2, 3, 4, 30, 1, 2, 1'b0);
    // R11: second start while busy
    run_case(0, 6, 2, 10, 0, 4, 3, 20, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 global watchdog expired: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule